// File: doc/BRIEF.md
# Associative Page Lookup

This unit translates word addresses of a one-level store into core-store addresses. A bank of page registers, one per physical core page, records which 512-word block each page currently holds and whether that record is valid. Each request's block field is compared against every register in the same cycle. When one register matches, the request is granted and the physical address is formed from the page number and the unchanged word offset. When none matches, the request is held and a sticky miss interrupt flag is raised. Supervisor software services the miss, loads a register, and the requester then retries.

Software reaches the unit through two small ports. The page port writes one register at a time: its block number and its valid bit. The status port has two locations. One holds the miss interrupt flag, which is cleared by writing 1. The other holds a per-page mask of recently used pages. Each granted access sets that page's bit, and reading the mask clears it. This gives a replacement routine the information it needs when choosing a page to evict.

Top module: `assoc_page_lookup`

## Requirements
- R1: After synchronous reset every page register is invalid, the interrupt flag is 0 and the used mask is all zero, so any request is held.
- R2: A page register write updates that register at the next clock edge. A request in the same cycle as the write still sees the old contents.
- R3: A valid request whose block field (address bits 16:9) equals the block of exactly one valid register raises req_grant with req_hold low, in the same cycle. phys_addr is {page index, address bits 8:0}.
- R4: A valid request that matches no valid register raises req_hold with req_grant low. At the next edge the interrupt flag is set, and it stays set.
- R5: Writing st_wdata=1 with st_sel=0 clears the interrupt flag at the next edge. Writing 0 leaves it unchanged. A miss in the same cycle as the clearing write keeps the flag set.
- R6: Each granted request sets bit <page> of the used mask at the next edge. A read with st_sel=1 returns the mask and clears it at the next edge, except for bits set by a grant in that same cycle.
- R7: A register whose valid bit is 0 never matches, even when its stored block equals the request's block.
- R8: With req_valid low, req_grant and req_hold are both 0 and the interrupt flag is not affected.
- R9: A request that missed is granted once it is retried after its block has been written into a page register.
- R10: st_rdata with st_sel=0 is the interrupt flag in bit 0, with all other bits 0. With st_sel=1 it is the used mask, bit i for page i.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request present |
| req_addr | input | 17 | Word address: block in bits 16:9, offset in bits 8:0 |
| req_grant | output | 1 | Equivalence: the access may proceed |
| req_hold | output | 1 | Non-equivalence: the requester must wait |
| phys_addr | output | 14 | Core address {page, offset}; zero when not granted |
| irq | output | 1 | Sticky miss interrupt flag |
| pa_we | input | 1 | Page register write strobe |
| pa_idx | input | 5 | Page register selected for the write |
| pa_block | input | 8 | Block number to store |
| pa_valid | input | 1 | Valid bit to store |
| st_rd | input | 1 | Status read strobe (clears the used mask when st_sel=1) |
| st_wr | input | 1 | Status write strobe |
| st_sel | input | 1 | Status location: 0 interrupt flag, 1 used mask |
| st_wdata | input | 1 | Status write data (1 clears the interrupt flag) |
| st_rdata | output | 32 | Status read data |

## Verification
The hardest situations to reach are the ones where software and the requester collide in a single cycle. These are a register write arriving together with a request for the block it installs, a clearing write together with a new miss, and a read-and-clear of the used mask together with a grant. The stimulus drives both ports on the same falling edge for each of these cases. It then reads the state that results back through the status port on the following cycle. The full miss, reload and retry sequence is also driven end to end.

// File: rtl/pal_pkg.sv
package pal_pkg;
    localparam int NUM_PAGES = 32;
    localparam int OFFSET_W  = 9;
    localparam int BLOCK_W   = 8;
    localparam int PAGE_W    = $clog2(NUM_PAGES);
    localparam int VADDR_W   = BLOCK_W + OFFSET_W;
    localparam int PADDR_W   = PAGE_W + OFFSET_W;

    typedef logic [BLOCK_W-1:0]  block_t;
    typedef logic [PAGE_W-1:0]   page_t;
    typedef logic [OFFSET_W-1:0] offset_t;
    typedef logic [VADDR_W-1:0]  vaddr_t;
    typedef logic [PADDR_W-1:0]  paddr_t;
    typedef logic [NUM_PAGES-1:0] page_mask_t;

    typedef struct packed {
        logic   valid;
        block_t block;
    } page_entry_t;

    typedef enum logic {
        SEL_IRQ  = 1'b0,
        SEL_USED = 1'b1
    } stat_sel_e;

    function automatic block_t block_of(vaddr_t a);
        return a[VADDR_W-1:OFFSET_W];
    endfunction

    function automatic offset_t offset_of(vaddr_t a);
        return a[OFFSET_W-1:0];
    endfunction
endpackage

// File: rtl/pal_entry_array.sv
module pal_entry_array
    import pal_pkg::*;
#(
    parameter int N = NUM_PAGES
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        wr_en,
    input  page_t       wr_idx,
    input  page_entry_t wr_entry,
    input  block_t      lk_block,
    output logic [N-1:0] hit_vec
);
    page_entry_t entry_q [N];

    for (genvar i = 0; i < N; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                entry_q[i] <= '0;
            end else if (wr_en && (int'(wr_idx) == i)) begin
                entry_q[i] <= wr_entry;
            end
        end
        assign hit_vec[i] = entry_q[i].valid && (entry_q[i].block == lk_block);
    end
endmodule

// File: rtl/pal_encoder.sv
module pal_encoder
    import pal_pkg::*;
#(
    parameter int N = NUM_PAGES
) (
    input  logic [N-1:0] vec,
    output page_t        idx,
    output logic         any
);
    always_comb begin
        idx = '0;
        for (int i = 0; i < N; i++) begin
            if (vec[i]) idx = idx | page_t'(i);
        end
    end
    assign any = |vec;
endmodule

// File: rtl/pal_status.sv
module pal_status
    import pal_pkg::*;
#(
    parameter int N = NUM_PAGES
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         miss_evt,
    input  logic         clr_irq,
    input  logic [N-1:0] hit_set,
    input  logic         clr_used,
    output logic         irq,
    output logic [N-1:0] used_mask
);
    always_ff @(posedge clk) begin
        if (rst) begin
            irq <= 1'b0;
        end else if (miss_evt) begin
            irq <= 1'b1;
        end else if (clr_irq) begin
            irq <= 1'b0;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            used_mask <= '0;
        end else begin
            used_mask <= (clr_used ? '0 : used_mask) | hit_set;
        end
    end
endmodule

// File: rtl/assoc_page_lookup.sv
module assoc_page_lookup
    import pal_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 req_valid,
    input  logic [VADDR_W-1:0]   req_addr,
    output logic                 req_grant,
    output logic                 req_hold,
    output logic [PADDR_W-1:0]   phys_addr,
    output logic                 irq,
    input  logic                 pa_we,
    input  logic [PAGE_W-1:0]    pa_idx,
    input  logic [BLOCK_W-1:0]   pa_block,
    input  logic                 pa_valid,
    input  logic                 st_rd,
    input  logic                 st_wr,
    input  logic                 st_sel,
    input  logic                 st_wdata,
    output logic [NUM_PAGES-1:0] st_rdata
);
    page_mask_t  hit_vec;
    page_mask_t  used_mask;
    page_t       hit_page;
    logic        hit_any;
    page_entry_t wr_entry;
    stat_sel_e   sel;

    assign wr_entry = '{valid: pa_valid, block: pa_block};
    assign sel      = stat_sel_e'(st_sel);

    pal_entry_array #(.N(NUM_PAGES)) u_array (
        .clk      (clk),
        .rst      (rst),
        .wr_en    (pa_we),
        .wr_idx   (pa_idx),
        .wr_entry (wr_entry),
        .lk_block (block_of(req_addr)),
        .hit_vec  (hit_vec)
    );

    pal_encoder #(.N(NUM_PAGES)) u_enc (
        .vec (hit_vec),
        .idx (hit_page),
        .any (hit_any)
    );

    assign req_grant = req_valid && hit_any;
    assign req_hold  = req_valid && !hit_any;
    assign phys_addr = req_grant ? {hit_page, offset_of(req_addr)} : '0;

    pal_status #(.N(NUM_PAGES)) u_status (
        .clk       (clk),
        .rst       (rst),
        .miss_evt  (req_hold),
        .clr_irq   (st_wr && (sel == SEL_IRQ) && st_wdata),
        .hit_set   (req_valid ? hit_vec : '0),
        .clr_used  (st_rd && (sel == SEL_USED)),
        .irq       (irq),
        .used_mask (used_mask)
    );

    always_comb begin
        if (sel == SEL_USED) st_rdata = used_mask;
        else                 st_rdata = {{(NUM_PAGES-1){1'b0}}, irq};
    end
endmodule

// File: rtl/pal_checker.sv
module pal_checker
    import pal_pkg::*;
(
    input logic                 clk,
    input logic                 rst,
    input logic                 req_valid,
    input logic                 req_grant,
    input logic                 req_hold,
    input logic [PADDR_W-1:0]   phys_addr,
    input logic                 irq,
    input logic                 st_wr,
    input logic                 st_sel,
    input logic                 st_wdata,
    input logic [NUM_PAGES-1:0] hit_vec,
    input logic [NUM_PAGES-1:0] used_mask
);
    p_excl_r3: assert property (@(posedge clk) disable iff (rst)
        !(req_grant && req_hold));

    // R3: at most one page register may match any block
    p_unique_match_r3: assert property (@(posedge clk) disable iff (rst)
        $onehot0(hit_vec));

    p_miss_irq_r4: assert property (@(posedge clk) disable iff (rst)
        req_hold |=> irq);

    p_irq_sticky_r5: assert property (@(posedge clk) disable iff (rst)
        (irq && !(st_wr && !st_sel && st_wdata)) |=> irq);

    p_used_set_r6: assert property (@(posedge clk) disable iff (rst)
        req_grant |=> used_mask[$past(phys_addr[PADDR_W-1:OFFSET_W])]);

    p_idle_r8: assert property (@(posedge clk) disable iff (rst)
        !req_valid |-> (!req_grant && !req_hold));
endmodule

bind assoc_page_lookup pal_checker u_chk (
    .clk       (clk),
    .rst       (rst),
    .req_valid (req_valid),
    .req_grant (req_grant),
    .req_hold  (req_hold),
    .phys_addr (phys_addr),
    .irq       (irq),
    .st_wr     (st_wr),
    .st_sel    (st_sel),
    .st_wdata  (st_wdata),
    .hit_vec   (hit_vec),
    .used_mask (used_mask)
);

// File: tb/assoc_page_lookup_bench.sv
module assoc_page_lookup_bench;
    import pal_pkg::*;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic req_valid = 1'b0;
    logic [VADDR_W-1:0] req_addr = '0;
    logic req_grant, req_hold, irq;
    logic [PADDR_W-1:0] phys_addr;
    logic pa_we = 1'b0;
    logic [PAGE_W-1:0] pa_idx = '0;
    logic [BLOCK_W-1:0] pa_block = '0;
    logic pa_valid = 1'b0;
    logic st_rd = 1'b0, st_wr = 1'b0, st_sel = 1'b0, st_wdata = 1'b0;
    logic [NUM_PAGES-1:0] st_rdata;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    assoc_page_lookup u_assoc_page_lookup (.*);

    // {block, offset, expect hit, expect page}; page p holds block 10+3p
    localparam int VW = BLOCK_W + OFFSET_W + 1 + PAGE_W;
    localparam logic [VW-1:0] VEC [8] = '{
        {8'd10,  9'd0,   1'b1, 5'd0},
        {8'd103, 9'd511, 1'b1, 5'd31},
        {8'd55,  9'd77,  1'b1, 5'd15},
        {8'd11,  9'd3,   1'b0, 5'd0},
        {8'd191, 9'd100, 1'b0, 5'd0},
        {8'd0,   9'd0,   1'b0, 5'd0},
        {8'd13,  9'd5,   1'b1, 5'd1},
        {8'd40,  9'd256, 1'b1, 5'd10}
    };

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic wr_page(input int idx, input int blk, input bit v);
        @(negedge clk);
        pa_we = 1'b1; pa_idx = PAGE_W'(idx); pa_block = BLOCK_W'(blk); pa_valid = v;
        @(negedge clk);
        pa_we = 1'b0;
    endtask

    task automatic clear_irq();
        @(negedge clk);
        st_wr = 1'b1; st_sel = 1'b0; st_wdata = 1'b1;
        @(negedge clk);
        st_wr = 1'b0; st_wdata = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual 0 expected 1");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        logic [NUM_PAGES-1:0] exp_used;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        #1;
        // R1 reset state
        chk(irq == 1'b0, "R1 irq", irq, 0);
        st_sel = 1'b1; #1;
        chk(st_rdata == '0, "R1 used", st_rdata, 0);
        st_sel = 1'b0;
        req_valid = 1'b1; req_addr = {8'd10, 9'd0}; #1;
        chk(req_hold == 1'b1 && req_grant == 1'b0, "R1 empty miss", req_hold, 1);
        @(negedge clk); req_valid = 1'b0; #1;
        chk(irq == 1'b1, "R4 irq set", irq, 1);
        // R5 write 0 has no effect
        @(negedge clk); st_wr = 1'b1; st_sel = 1'b0; st_wdata = 1'b0;
        @(negedge clk); st_wr = 1'b0; #1;
        chk(irq == 1'b1, "R5 write 0 ignored", irq, 1);
        chk(st_rdata == 32'h1, "R10 status irq", st_rdata, 1);
        clear_irq(); #1;
        chk(irq == 1'b0, "R5 clear", irq, 0);
        chk(st_rdata == 32'h0, "R10 status cleared", st_rdata, 0);

        // R2 write and request same cycle
        @(negedge clk);
        pa_we = 1'b1; pa_idx = 0; pa_block = 8'd10; pa_valid = 1'b1;
        req_valid = 1'b1; req_addr = {8'd10, 9'd33}; #1;
        chk(req_hold == 1'b1, "R2 old contents", req_hold, 1);
        @(negedge clk); pa_we = 1'b0; #1;
        chk(req_grant == 1'b1 && phys_addr == {5'd0, 9'd33}, "R2 new contents", phys_addr, {5'd0, 9'd33});
        @(negedge clk); req_valid = 1'b0;
        clear_irq();
        for (int p = 1; p < NUM_PAGES; p++) wr_page(p, 10 + 3 * p, 1'b1);

        // R3/R4 table walk
        exp_used = 32'h1;
        for (int i = 0; i < 8; i++) begin
            logic [VW-1:0] v;
            v = VEC[i];
            @(negedge clk);
            req_valid = 1'b1;
            req_addr = v[VW-1:PAGE_W+1];
            #1;
            if (v[PAGE_W]) begin
                chk(req_grant && !req_hold, "R3 grant", req_grant, 1);
                chk(phys_addr == {v[PAGE_W-1:0], v[PAGE_W+1 +: OFFSET_W]}, "R3 phys",
                    phys_addr, {v[PAGE_W-1:0], v[PAGE_W+1 +: OFFSET_W]});
                exp_used[v[PAGE_W-1:0]] = 1'b1;
            end else begin
                chk(req_hold && !req_grant, "R4 hold", req_hold, 1);
                chk(phys_addr == '0, "R4 phys zero", phys_addr, 0);
            end
        end
        @(negedge clk); req_valid = 1'b0; #1;
        chk(irq == 1'b1, "R4 sticky", irq, 1);

        // R6 read-and-clear with a concurrent hit on page 3 (block 19)
        st_sel = 1'b1; st_rd = 1'b1; req_valid = 1'b1; req_addr = {8'd19, 9'd0}; #1;
        chk(st_rdata == exp_used, "R6 used mask", st_rdata, exp_used);
        @(negedge clk); st_rd = 1'b0; req_valid = 1'b0; #1;
        chk(st_rdata == 32'h8, "R6 clear keeps same-cycle hit", st_rdata, 32'h8);
        st_sel = 1'b0;

        // R5 clear collides with miss
        @(negedge clk);
        st_wr = 1'b1; st_wdata = 1'b1; req_valid = 1'b1; req_addr = {8'd200, 9'd1};
        @(negedge clk); st_wr = 1'b0; st_wdata = 1'b0; req_valid = 1'b0; #1;
        chk(irq == 1'b1, "R5 miss wins", irq, 1);
        clear_irq(); #1;
        chk(irq == 1'b0, "R5 clear again", irq, 0);

        // R7 invalid register never matches
        wr_page(5, 25, 1'b0);
        @(negedge clk); req_valid = 1'b1; req_addr = {8'd25, 9'd9}; #1;
        chk(req_hold == 1'b1 && req_grant == 1'b0, "R7 invalid entry", req_grant, 0);
        @(negedge clk); req_valid = 1'b0;
        clear_irq();

        // R8 idle request
        @(negedge clk); req_valid = 1'b0; req_addr = {8'd200, 9'd0}; #1;
        chk(!req_grant && !req_hold, "R8 idle outputs", req_hold, 0);
        @(negedge clk); #1;
        chk(irq == 1'b0, "R8 irq untouched", irq, 0);

        // R9 miss, reload, retry
        @(negedge clk); req_valid = 1'b1; req_addr = {8'd150, 9'd300}; #1;
        chk(req_hold == 1'b1, "R9 initial miss", req_hold, 1);
        @(negedge clk); req_valid = 1'b0;
        wr_page(5, 150, 1'b1);
        @(negedge clk); req_valid = 1'b1; #1;
        chk(req_grant == 1'b1 && phys_addr == {5'd5, 9'd300}, "R9 retry hit", phys_addr, {5'd5, 9'd300});
        @(negedge clk); req_valid = 1'b0;

        // R1 reset again empties registers
        rst = 1'b1; @(negedge clk); rst = 1'b0;
        req_valid = 1'b1; req_addr = {8'd150, 9'd0}; #1;
        chk(req_hold == 1'b1 && irq == 1'b0, "R1 reset clears entries", req_hold, 1);
        @(negedge clk); req_valid = 1'b0;

        done = 1'b1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule